// File: doc/BRIEF.md
# Pulse-Width Byte Decoder with Flag Check

This block turns a stream of timed full pulses into bytes and judges a whole recorded block. An external interval detector measures each pulse: the decoder asks for a measurement, tells the detector which counter start value to use, and receives either a final count or a timeout. A count above a fixed threshold is a one and anything else is a zero. Bits arrive most significant first. A marker bit travelling through the shift register tells the decoder when a byte is complete, so no separate bit counter is needed.

The first byte of a block is a flag byte that must equal an expected value. After it come the data bytes and then one check byte. An XOR of every byte, counting the flag and the check byte, must come to zero. In load mode each data byte goes out on a write port at consecutive addresses from a base address. In verify mode each data byte is compared with a reference byte that the surrounding memory returns for the current address. The block finishes with a one-cycle done pulse, a success bit and a failure cause.

Top module: `pwbd_top`

## Requirements
- R1: After reset, busy, done, ok, wr_en and meas_req are 0 and fail_cause is 0.
- R2: A measured count greater than 0xCB decodes as a 1 and any count of 0xCB or below decodes as a 0, so 0xCB gives 0 and 0xCC gives 1.
- R3: Bits are assembled most significant first, and a byte is complete on its eighth accepted measurement.
- R4: While meas_req is high, meas_seed is 0xB2 for the first bit of every byte after the flag byte and 0xB0 for every other bit, the flag byte's bits included.
- R5: If the first byte differs from the expected flag, the block ends with fail_cause 2 and writes nothing.
- R6: In load mode, data byte k (counting from 0) is written with wr_en at address base_addr + k in the cycle its last bit is accepted; the check byte is never written.
- R7: In verify mode, wr_en never rises, and a data byte that differs from ref_data at mem_addr ends the block with fail_cause 3.
- R8: The XOR of the flag, all data bytes and the check byte must be zero: then done comes with ok = 1 and fail_cause 0, otherwise with ok = 0 and fail_cause 4.
- R9: After the flag exactly len + 1 bytes are taken; with len = 0 only the check byte follows the flag.
- R10: meas_timeout while busy ends the block with fail_cause 1, and takes precedence over meas_done in the same cycle.
- R11: start while busy is ignored (the command fields are captured only at an accepted start), and meas_done while idle has no effect.
- R12: done is high for exactly one cycle, on the same edge that busy falls; ok and fail_cause hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block; honoured only when idle |
| mode_load | input | 1 | 1 = load (write data bytes), 0 = verify (compare) |
| flag_exp | input | 8 | Expected flag byte |
| len | input | 16 | Number of data bytes between flag and check byte |
| base_addr | input | 16 | Address of the first data byte |
| meas_req | output | 1 | Request for a full-pulse measurement |
| meas_seed | output | 8 | Counter start value for the requested measurement |
| meas_done | input | 1 | One-cycle strobe: a measurement finished |
| meas_timeout | input | 1 | One-cycle strobe: the measurement timed out |
| meas_count | input | 8 | Final count of the finished measurement |
| wr_en | output | 1 | Write strobe for a data byte (load mode) |
| mem_addr | output | 16 | Address for write and for the reference byte |
| wr_data | output | 8 | Data byte to write |
| ref_data | input | 8 | Reference byte at mem_addr (verify mode) |
| busy | output | 1 | A block is being decoded |
| done | output | 1 | One-cycle end-of-block pulse |
| ok | output | 1 | Block accepted |
| fail_cause | output | 3 | 0 none, 1 timeout, 2 flag, 3 verify, 4 checksum |

## Verification
The bench drives counts of exactly 0xCB and 0xCC, so a design with an off-by-one threshold or a reversed bit order writes wrong bytes that the reference queue catches. Blocks with len = 0 and with a corrupted check byte expose a design that writes the check byte, takes one byte too few or too many, or leaves the flag out of the checksum. A timeout that arrives together with meas_done, and a start pulse in the middle of a block with different command fields, catch a decoder that lets a finished measurement win or that re-launches while busy. Every bit request is checked for its counter start value, which a design that only switches the seed on the flag byte would get wrong.

// File: rtl/pwbd_pkg.sv
package pwbd_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE     = 3'd0,
      CAUSE_TIMEOUT  = 3'd1,
      CAUSE_FLAG     = 3'd2,
      CAUSE_VERIFY   = 3'd3,
      CAUSE_CHECKSUM = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_FLAG = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

endpackage

// File: rtl/pwbd_bit_slicer.sv
module pwbd_bit_slicer #(
   parameter int CNT_W     = 8,
   parameter int BYTE_W    = 8,
   parameter int THRESH    = 'hCB,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic [CNT_W-1:0]  meas_count,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);
   localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

   logic              bit_v;
   logic              full;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_nxt;
   logic [BYTE_W-1:0] marker;

   // a long pulse is a one
   assign bit_v = (meas_count > THR_V);

   generate
      if (MSB_FIRST) begin : g_msb
         assign marker = BYTE_W'(1);
         assign sh_nxt = {sh_q[BYTE_W-2:0], bit_v};
         assign full   = sh_q[BYTE_W-1];
      end else begin : g_lsb
         assign marker = {1'b1, {(BYTE_W-1){1'b0}}};
         assign sh_nxt = {bit_v, sh_q[BYTE_W-1:1]};
         assign full   = sh_q[0];
      end
   endgenerate

   // the marker reaching the far end means this bit completes the byte
   assign byte_done = shift_en & full;
   assign byte_val  = sh_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sh_q <= marker;
      else if (clear || byte_done) sh_q <= marker;
      else if (shift_en)           sh_q <= sh_nxt;
   end

endmodule

// File: rtl/pwbd_byte_judge.sv
module pwbd_byte_judge #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [BYTE_W-1:0] flag_exp,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [BYTE_W-1:0] ref_byte,
   output logic              flag_bad,
   output logic              ref_bad,
   output logic              sum_bad
);
   logic [BYTE_W-1:0] flag_q;
   logic [BYTE_W-1:0] xacc_q;

   assign flag_bad = (byte_in != flag_q);
   assign ref_bad  = (byte_in != ref_byte);
   assign sum_bad  = ((xacc_q ^ byte_in) != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         xacc_q <= '0;
      end else if (clear) begin
         flag_q <= flag_exp;
         xacc_q <= '0;
      end else if (take) begin
         xacc_q <= xacc_q ^ byte_in;
      end
   end

endmodule

// File: rtl/pwbd_ctrl.sv
module pwbd_ctrl
   import pwbd_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_load,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              meas_done,
   input  logic              meas_timeout,
   input  logic              byte_done,
   input  logic              flag_bad,
   input  logic              ref_bad,
   input  logic              sum_bad,
   output logic              busy,
   output logic              meas_req,
   output logic              shift_en,
   output logic              first_bit,
   output logic              clear,
   output logic              take,
   output logic              wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              load_q,
   output logic              done,
   output logic              ok,
   output logic [2:0]        cause
);
   localparam int REM_W = LEN_W + 1;

   phase_e            ph_q;
   logic [REM_W-1:0]  rem_q;
   logic [ADDR_W-1:0] addr_q;
   logic              first_q;
   logic              load_r;
   logic              done_q;
   logic              ok_q;
   cause_e            cause_q;
   cause_e            fin_cause;
   logic              fin;
   logic              launch;
   logic              in_flag;
   logic              last_byte;
   logic              data_byte;

   assign busy      = (ph_q != PH_IDLE);
   assign launch    = start & ~busy;
   assign shift_en  = busy & meas_done & ~meas_timeout;
   assign in_flag   = (ph_q == PH_FLAG);
   assign last_byte = (ph_q == PH_DATA) && (rem_q == REM_W'(1));
   assign data_byte = (ph_q == PH_DATA) && !last_byte;

   always_comb begin
      fin       = 1'b0;
      fin_cause = CAUSE_NONE;
      if (busy && meas_timeout) begin
         fin       = 1'b1;
         fin_cause = CAUSE_TIMEOUT;
      end else if (byte_done) begin
         if (in_flag && flag_bad) begin
            fin       = 1'b1;
            fin_cause = CAUSE_FLAG;
         end else if (data_byte && !load_r && ref_bad) begin
            fin       = 1'b1;
            fin_cause = CAUSE_VERIFY;
         end else if (last_byte) begin
            fin       = 1'b1;
            fin_cause = sum_bad ? CAUSE_CHECKSUM : CAUSE_NONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         rem_q   <= '0;
         addr_q  <= '0;
         first_q <= 1'b0;
         load_r  <= 1'b0;
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else begin
         done_q <= 1'b0;
         if (launch) begin
            ph_q    <= PH_FLAG;
            rem_q   <= REM_W'(len) + REM_W'(1);
            addr_q  <= base_addr;
            first_q <= 1'b0;
            load_r  <= mode_load;
            ok_q    <= 1'b0;
            cause_q <= CAUSE_NONE;
         end else if (fin) begin
            ph_q    <= PH_IDLE;
            done_q  <= 1'b1;
            ok_q    <= (fin_cause == CAUSE_NONE);
            cause_q <= fin_cause;
         end else if (byte_done) begin
            first_q <= 1'b1;
            if (in_flag) begin
               ph_q <= PH_DATA;
            end else begin
               addr_q <= addr_q + ADDR_W'(1);
               rem_q  <= rem_q - REM_W'(1);
            end
         end else if (shift_en) begin
            first_q <= 1'b0;
         end
      end
   end

   assign meas_req  = busy;
   assign first_bit = first_q;
   assign clear     = launch;
   assign take      = byte_done;
   assign wr_en     = byte_done & data_byte & load_r;
   assign mem_addr  = addr_q;
   assign load_q    = load_r;
   assign done      = done_q;
   assign ok        = ok_q;
   assign cause     = cause_q;

endmodule

// File: rtl/pwbd_top.sv
module pwbd_top #(
   parameter int LEN_W     = 16,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int BYTE_W    = 8,
   parameter int THRESH    = 'hCB,
   parameter int SEED_BIT  = 'hB0,
   parameter int SEED_LEAD = 'hB2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_load,
   input  logic [BYTE_W-1:0] flag_exp,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              meas_req,
   output logic [CNT_W-1:0]  meas_seed,
   input  logic              meas_done,
   input  logic              meas_timeout,
   input  logic [CNT_W-1:0]  meas_count,
   output logic              wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] ref_data,
   output logic              busy,
   output logic              done,
   output logic              ok,
   output logic [2:0]        fail_cause
);
   localparam logic [CNT_W-1:0] SEED_BIT_V  = CNT_W'(SEED_BIT);
   localparam logic [CNT_W-1:0] SEED_LEAD_V = CNT_W'(SEED_LEAD);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("pwbd_top: BYTE_W must be at least 2");
      end
      if (LEN_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("pwbd_top: LEN_W and ADDR_W must be positive");
      end
      if (THRESH >= (1 << CNT_W) || SEED_BIT >= (1 << CNT_W) || SEED_LEAD >= (1 << CNT_W)) begin : g_bad_cnt
         $error("pwbd_top: threshold and seeds must fit in CNT_W bits");
      end
   endgenerate

   logic              shift_en;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_val;
   logic              first_bit;
   logic              clear;
   logic              take;
   logic              flag_bad;
   logic              ref_bad;
   logic              sum_bad;
   logic              load_q;

   pwbd_bit_slicer #(
      .CNT_W(CNT_W), .BYTE_W(BYTE_W), .THRESH(THRESH), .MSB_FIRST(MSB_FIRST)
   ) u_slice (
      .clk(clk), .rst_n(rst_n), .clear(clear), .shift_en(shift_en),
      .meas_count(meas_count), .byte_done(byte_done), .byte_val(byte_val)
   );

   pwbd_byte_judge #(.BYTE_W(BYTE_W)) u_judge (
      .clk(clk), .rst_n(rst_n), .clear(clear), .take(take),
      .flag_exp(flag_exp), .byte_in(byte_val), .ref_byte(ref_data),
      .flag_bad(flag_bad), .ref_bad(ref_bad), .sum_bad(sum_bad)
   );

   pwbd_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_load(mode_load),
      .len(len), .base_addr(base_addr), .meas_done(meas_done),
      .meas_timeout(meas_timeout), .byte_done(byte_done),
      .flag_bad(flag_bad), .ref_bad(ref_bad), .sum_bad(sum_bad),
      .busy(busy), .meas_req(meas_req), .shift_en(shift_en),
      .first_bit(first_bit), .clear(clear), .take(take), .wr_en(wr_en),
      .mem_addr(mem_addr), .load_q(load_q), .done(done), .ok(ok),
      .cause(fail_cause)
   );

   assign meas_seed = first_bit ? SEED_LEAD_V : SEED_BIT_V;
   assign wr_data   = byte_val;

endmodule

// File: rtl/pwbd_chk.sv
module pwbd_chk #(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int SEED_BIT  = 'hB0,
   parameter int SEED_LEAD = 'hB2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ok,
   input logic [2:0]        fail_cause,
   input logic              wr_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              meas_req,
   input logic [CNT_W-1:0]  meas_seed,
   input logic              meas_timeout,
   input logic              load_q
);
   localparam logic [CNT_W-1:0] SB = CNT_W'(SEED_BIT);
   localparam logic [CNT_W-1:0] SL = CNT_W'(SEED_LEAD);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!meas_req && !wr_en)); // R11
   AST_WR_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> load_q); // R7
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R6
   AST_SEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      meas_req |-> (meas_seed == SB || meas_seed == SL)); // R4
   AST_TIMEOUT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && meas_timeout) |=> (done && fail_cause == 3'd1)); // R10
   AST_OK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok == (fail_cause == 3'd0))); // R8

endmodule

bind pwbd_top pwbd_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEED_BIT(SEED_BIT), .SEED_LEAD(SEED_LEAD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ok(ok),
   .fail_cause(fail_cause), .wr_en(wr_en), .mem_addr(mem_addr),
   .meas_req(meas_req), .meas_seed(meas_seed), .meas_timeout(meas_timeout),
   .load_q(load_q)
);

// File: tb/sim_pwbd_top.sv
`timescale 1ns/1ps
module sim_pwbd_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode_load = 1'b0;
   logic [7:0]  flag_exp = 8'h00;
   logic [15:0] len = 16'h0;
   logic [15:0] base_addr = 16'h0;
   logic        meas_req;
   logic [7:0]  meas_seed;
   logic        meas_done = 1'b0;
   logic        meas_timeout = 1'b0;
   logic [7:0]  meas_count = 8'h00;
   logic        wr_en;
   logic [15:0] mem_addr;
   logic [7:0]  wr_data;
   logic [7:0]  ref_data;
   logic        busy, done, ok;
   logic [2:0]  fail_cause;

   int n_cmp = 0;
   int n_bad = 0;
   logic        exp_wr = 1'b0;
   logic [15:0] exp_addr = 16'h0;
   logic [7:0]  exp_data = 8'h00;
   logic [7:0]  vmem [64];
   logic [7:0]  strm [$];

   always #10 clk = ~clk;

   assign ref_data = vmem[mem_addr[5:0]];

   pwbd_top u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_load(mode_load),
      .flag_exp(flag_exp), .len(len), .base_addr(base_addr),
      .meas_req(meas_req), .meas_seed(meas_seed), .meas_done(meas_done),
      .meas_timeout(meas_timeout), .meas_count(meas_count), .wr_en(wr_en),
      .mem_addr(mem_addr), .wr_data(wr_data), .ref_data(ref_data),
      .busy(busy), .done(done), .ok(ok), .fail_cause(fail_cause)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference write stream compared on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         chk(mode_load ? "R6" : "R7", "wr_en", int'(wr_en), int'(exp_wr));
         if (exp_wr && wr_en) begin
            chk("R6", "write address", int'(mem_addr), int'(exp_addr));
            chk("R3", "write data", int'(wr_data), int'(exp_data));
         end
      end
   end

   task automatic mk(input logic [7:0] f, input int n, input int seed, input bit bad_sum);
      logic [7:0] x;
      strm.delete();
      strm.push_back(f);
      x = f;
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = 8'((seed * 37 + k * 91 + 5) & 255);
         strm.push_back(d);
         x = x ^ d;
      end
      strm.push_back(x ^ (bad_sum ? 8'h01 : 8'h00));
   endtask

   task automatic fill_ref(input logic [15:0] ba, input int n);
      for (int k = 0; k < n; k++) vmem[(int'(ba) + k) % 64] = strm[k + 1];
   endtask

   task automatic send_bit(input int bi, input int ki, input bit val, input bit tmo,
                           input bit tmo_done, input bit wexp,
                           input logic [15:0] wa, input logic [7:0] wd);
      int guard = 0;
      while (!meas_req && guard < 1000) begin
         @(posedge clk); #1;
         guard++;
      end
      chk("R4", "meas_seed", int'(meas_seed), (bi > 0 && ki == 0) ? 'hB2 : 'hB0);
      for (int g = 0; g < (bi + ki) % 3; g++) begin
         @(posedge clk); #1;
      end
      meas_count   = val ? (ki[0] ? 8'hCC : 8'hF1) : (ki[0] ? 8'hCB : 8'h37);
      meas_done    = !tmo || tmo_done;
      meas_timeout = tmo;
      exp_wr   = wexp;
      exp_addr = wa;
      exp_data = wd;
      @(posedge clk); #1;
      meas_done    = 1'b0;
      meas_timeout = 1'b0;
      exp_wr       = 1'b0;
   endtask

   task automatic xfer(input bit ld, input logic [7:0] fe, input int n,
                       input logic [15:0] ba, input int tmo_at, input bit tmo_done,
                       input bit mid_start, input string tag);
      int stop;
      int ec;
      logic [7:0] xr;
      string rt;
      stop = n + 1;
      ec = 0;
      xr = 8'h00;
      for (int b = 0; b <= n + 1; b++) begin
         if (tmo_at >= 0 && tmo_at / 8 == b) begin ec = 1; stop = b; break; end
         if (b == 0 && strm[0] != fe) begin ec = 2; stop = 0; break; end
         if (b >= 1 && b <= n && !ld && strm[b] != vmem[(int'(ba) + b - 1) % 64]) begin
            ec = 3; stop = b; break;
         end
         xr = xr ^ strm[b];
         if (b == n + 1 && xr != 8'h00) ec = 4;
      end
      rt = (ec == 1) ? "R10" : (ec == 2) ? "R5" : (ec == 3) ? "R7" : "R8";

      mode_load = ld; flag_exp = fe; len = 16'(n); base_addr = ba; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      chk("R12", "busy after start", int'(busy), 1);

      for (int b = 0; b <= stop; b++) begin
         bit hit;
         hit = 1'b0;
         if (mid_start && b == 1) begin
            start = 1'b1; flag_exp = ~fe; base_addr = ba + 16'd7; mode_load = !ld; len = 16'd0;
            @(posedge clk); #1;
            start = 1'b0; flag_exp = fe; base_addr = ba; mode_load = ld; len = 16'(n);
            chk("R11", "busy kept on start", int'(busy), 1);
         end
         for (int i = 0; i < 8; i++) begin
            int g;
            bit istmo;
            g = b * 8 + i;
            istmo = (g == tmo_at);
            send_bit(b, i, strm[b][7 - i], istmo, tmo_done,
                     (i == 7) && ld && b >= 1 && b <= n && !istmo,
                     ba + 16'(b - 1), strm[b]);
            if (istmo) begin hit = 1'b1; break; end
         end
         if (hit) break;
      end

      chk({rt, " ", tag}, "done", int'(done), 1);
      chk({rt, " ", tag}, "ok", int'(ok), (ec == 0) ? 1 : 0);
      chk({rt, " ", tag}, "fail_cause", int'(fail_cause), ec);
      chk("R12", "busy low at done", int'(busy), 0);
      @(posedge clk); #1;
      chk("R12", "done width", int'(done), 0);
      chk("R12", "cause held", int'(fail_cause), ec);
      chk("R12", "ok held", int'(ok), (ec == 0) ? 1 : 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 64; k++) vmem[k] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "ok", int'(ok), 0);
      chk("R1", "fail_cause", int'(fail_cause), 0);
      chk("R1", "meas_req", int'(meas_req), 0);
      chk("R1", "wr_en", int'(wr_en), 0);

      // R11 measurements while idle
      meas_done = 1'b1; meas_count = 8'hFF;
      repeat (3) @(posedge clk);
      #1 meas_done = 1'b0;
      chk("R11", "busy idle", int'(busy), 0);
      chk("R11", "done idle", int'(done), 0);

      mk(8'h00, 3, 1, 1'b0);
      xfer(1'b1, 8'h00, 3, 16'h0010, -1, 1'b0, 1'b0, "load ok");

      mk(8'hFF, 4, 2, 1'b0);
      fill_ref(16'h0020, 4);
      xfer(1'b0, 8'hFF, 4, 16'h0020, -1, 1'b0, 1'b0, "verify ok");

      mk(8'hFF, 4, 3, 1'b0);
      fill_ref(16'h0020, 4);
      vmem[(16'h20 + 2) % 64] = vmem[(16'h20 + 2) % 64] ^ 8'h40;
      xfer(1'b0, 8'hFF, 4, 16'h0020, -1, 1'b0, 1'b0, "verify mismatch");

      mk(8'h5A, 2, 4, 1'b0);
      xfer(1'b1, 8'hA5, 2, 16'h0004, -1, 1'b0, 1'b0, "flag mismatch");

      mk(8'h00, 5, 5, 1'b1);
      xfer(1'b1, 8'h00, 5, 16'h0100, -1, 1'b0, 1'b0, "bad checksum");

      mk(8'h3C, 0, 6, 1'b0);
      xfer(1'b1, 8'h3C, 0, 16'h0008, -1, 1'b0, 1'b0, "R9 zero length");

      mk(8'h00, 2, 7, 1'b0);
      xfer(1'b1, 8'h00, 2, 16'h0040, 13, 1'b0, 1'b0, "timeout mid byte");

      mk(8'h00, 2, 8, 1'b0);
      xfer(1'b1, 8'h00, 2, 16'h0040, 8, 1'b1, 1'b0, "timeout with done");

      mk(8'h11, 3, 9, 1'b0);
      xfer(1'b1, 8'h11, 3, 16'h0030, -1, 1'b0, 1'b1, "R11 start while busy");

      strm.delete();
      strm.push_back(8'hAA); strm.push_back(8'h55); strm.push_back(8'hFF);
      strm.push_back(8'h00);
      xfer(1'b1, 8'hAA, 2, 16'h0002, -1, 1'b0, 1'b0, "R2 threshold edges");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule